// File: doc/BRIEF.md
# Full-Descending Stack Pointer Unit

This block owns the stack pointer of a word-addressed data memory and turns single-word push and pop requests into memory accesses. The stack grows toward lower addresses, and the pointer always names the most recently pushed word that is still occupied. A push moves the pointer down one word and writes the new data at the new address, so the current top is never overwritten. A pop reads the word at the pointer and frees the slot by moving the pointer up one word only after the read has been issued.

The memory side is a simple synchronous port. Write enable, read enable, address and write data are driven in the cycle that a request is accepted. Read data returns one cycle after the read enable. A push finishes in a single cycle. A pop takes two cycles: the read cycle and the data cycle. During the data cycle a busy flag is high and new requests are refused. A direct pointer load is provided for initialisation, and it overrides any push, pop or pending post-increment.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, `sp` equals `SP_RESET` with its low two bits cleared, `busy` and `pop_valid` are 0, and neither memory enable is asserted.
- R2: The two low bits of `sp` are always 0. A load of `sp_load_val` stores that value with bits 1:0 cleared.
- R3: A push accepted while idle, with no load, drives `mem_wr_en`=1, `mem_addr`=`sp`-4 and `mem_wr_data`=`push_data` in the same cycle. `sp` equals the old `sp`-4 from the next cycle, and `busy` stays 0.
- R4: A pop accepted while idle, with no push and no load, drives `mem_rd_en`=1 and `mem_addr`=`sp` in the same cycle. In the next cycle `pop_valid`=1 and `pop_data` carries the memory read data. `sp` then holds the old value plus 4 from the cycle after that.
- R5: `busy` is high for exactly the one cycle that follows an accepted pop. In that cycle, push and pop requests cause no memory access and do not affect `sp` beyond the pop's own increment.
- R6: When push and pop are requested together while idle, the push is performed and the pop is dropped.
- R7: When `sp_load` is high, `sp` takes the aligned load value in the next cycle. In that cycle no push or pop is performed. A pending pop increment is cancelled, but that pop still delivers its `pop_valid` and data.
- R8: Pointer arithmetic wraps modulo 2^`AW`, both below zero and above the top.
- R9: Pops return the pushed words in reverse order of their pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Request to push `push_data` |
| push_data | input | DW | Word to push |
| pop_req | input | 1 | Request to pop one word |
| sp_load | input | 1 | Direct pointer load strobe |
| sp_load_val | input | AW | Value for the direct load (low bits ignored) |
| busy | output | 1 | High during a pop's data cycle; requests refused |
| sp | output | AW | Current stack pointer |
| mem_wr_en | output | 1 | Memory write enable |
| mem_rd_en | output | 1 | Memory read enable |
| mem_addr | output | AW | Memory byte address |
| mem_wr_data | output | DW | Memory write data |
| mem_rd_data | input | DW | Memory read data, one cycle after `mem_rd_en` |
| pop_valid | output | 1 | Popped word valid on `pop_data` |
| pop_data | output | DW | Popped word |

## Verification
The bench builds the unit with `AW`=16, `DW`=16 and `SP_RESET`=16'h0008. With these values, three pushes from reset carry the pointer below address zero, and the wrap to 16'hFFFC becomes a directed check rather than an unreachable corner. A pseudo-random phase with occasional loads near both ends of the 16-bit space exercises wrap in both directions. It also covers the interaction of loads, busy cycles and same-cycle push and pop against the behavioural model.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_PUSH = 2'd2,
        OP_POP  = 2'd3
    } stk_op_e;

    typedef enum logic {
        PH_IDLE    = 1'b0,
        PH_POPWAIT = 1'b1
    } stk_phase_e;

endpackage

// File: rtl/stk_req_arb.sv
module stk_req_arb
    import stk_pkg::*;
(
    input  logic    push_req,
    input  logic    pop_req,
    input  logic    sp_load,
    input  logic    busy,
    output stk_op_e op
);

    // Load beats push, push beats pop; while busy only a load passes.
    always_comb begin
        op = OP_IDLE;
        if (sp_load) begin
            op = OP_LOAD;
        end else if (!busy) begin
            if (push_req) begin
                op = OP_PUSH;
            end else if (pop_req) begin
                op = OP_POP;
            end
        end
    end

endmodule

// File: rtl/stk_mem_if.sv
module stk_mem_if
    import stk_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  stk_op_e          op,
    input  logic [AW-1:0]    sp_cur,
    input  logic [DW-1:0]    push_data,
    output logic             mem_wr_en,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wr_data
);

    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    always_comb begin
        mem_wr_en   = 1'b0;
        mem_rd_en   = 1'b0;
        mem_addr    = sp_cur;
        mem_wr_data = push_data;
        unique case (op)
            OP_PUSH: begin
                mem_wr_en = 1'b1;
                mem_addr  = sp_cur - STEP;
            end
            OP_POP: begin
                mem_rd_en = 1'b1;
                mem_addr  = sp_cur;
            end
            default: begin
                mem_wr_en = 1'b0;
                mem_rd_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/stk_ptr_core.sv
module stk_ptr_core
    import stk_pkg::*;
#(
    parameter int              AW         = 32,
    parameter int              WORD_BYTES = 4,
    parameter logic [AW-1:0]   SP_RESET   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_op_e       op,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] sp_q,
    output logic          busy,
    output logic          pop_valid
);

    localparam int              ALIGN_BITS = $clog2(WORD_BYTES);
    localparam logic [AW-1:0]   STEP       = AW'(WORD_BYTES);
    localparam logic [AW-1:0]   ADDR_MASK  = {{(AW-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
    localparam logic [AW-1:0]   SP_RST_AL  = SP_RESET & ADDR_MASK;

    typedef struct packed {
        logic [AW-1:0] sp;
        stk_phase_e    ph;
        logic          vld;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (st_q.ph == PH_POPWAIT) begin
            st_d.ph = PH_IDLE;
            if (op == OP_LOAD) begin
                st_d.sp = load_val & ADDR_MASK;
            end else begin
                st_d.sp = st_q.sp + STEP;
            end
        end else begin
            unique case (op)
                OP_LOAD: st_d.sp = load_val & ADDR_MASK;
                OP_PUSH: st_d.sp = st_q.sp - STEP;
                OP_POP: begin
                    st_d.ph  = PH_POPWAIT;
                    st_d.vld = 1'b1;
                end
                default: st_d.sp = st_q.sp;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sp  <= SP_RST_AL;
            st_q.ph  <= PH_IDLE;
            st_q.vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sp_q      = st_q.sp;
    assign busy      = (st_q.ph == PH_POPWAIT);
    assign pop_valid = st_q.vld;

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op == OP_PUSH) |=> sp_q == $past(sp_q) - STEP); // R3
    AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op != OP_LOAD) |=> sp_q == $past(sp_q) + STEP); // R4
    AST_BUSY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R5
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> sp_q == ($past(load_val) & ADDR_MASK)); // R7
    AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q[ALIGN_BITS-1:0] == '0); // R2

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stk_pkg::*;
#(
    parameter int              AW         = 32,
    parameter int              DW         = 32,
    parameter int              WORD_BYTES = 4,
    parameter logic [AW-1:0]   SP_RESET   = 32'h0001_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    input  logic          sp_load,
    input  logic [AW-1:0] sp_load_val,
    output logic          busy,
    output logic [AW-1:0] sp,
    output logic          mem_wr_en,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wr_data,
    input  logic [DW-1:0] mem_rd_data,
    output logic          pop_valid,
    output logic [DW-1:0] pop_data
);

    stk_op_e op;

    stk_req_arb u_arb (
        .push_req (push_req),
        .pop_req  (pop_req),
        .sp_load  (sp_load),
        .busy     (busy),
        .op       (op)
    );

    stk_ptr_core #(
        .AW         (AW),
        .WORD_BYTES (WORD_BYTES),
        .SP_RESET   (SP_RESET)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .load_val  (sp_load_val),
        .sp_q      (sp),
        .busy      (busy),
        .pop_valid (pop_valid)
    );

    stk_mem_if #(
        .AW         (AW),
        .DW         (DW),
        .WORD_BYTES (WORD_BYTES)
    ) u_mem (
        .op          (op),
        .sp_cur      (sp),
        .push_data   (push_data),
        .mem_wr_en   (mem_wr_en),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_wr_data (mem_wr_data)
    );

    // Read data arrives exactly in the pop's data cycle.
    assign pop_data = mem_rd_data;

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!mem_wr_en && !mem_rd_en)); // R5
    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> pop_valid); // R4
    AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !busy && !sp_load) |-> (mem_wr_en && !mem_rd_en)); // R6
    AST_LOAD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        sp_load |-> (!mem_wr_en && !mem_rd_en)); // R7

endmodule

// File: tb/tb_stack_ptr_unit.sv
`timescale 1ns/100ps
module tb_stack_ptr_unit;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam logic [AW-1:0] RST_SP = 16'h0008;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_req = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic          pop_req = 1'b0;
    logic          sp_load = 1'b0;
    logic [AW-1:0] sp_load_val = '0;
    logic          busy, mem_wr_en, mem_rd_en, pop_valid;
    logic [AW-1:0] sp, mem_addr;
    logic [DW-1:0] mem_wr_data, pop_data;
    logic [DW-1:0] mem_rd_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    stack_ptr_unit #(.AW(AW), .DW(DW), .WORD_BYTES(4), .SP_RESET(RST_SP)) dut (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .sp_load(sp_load), .sp_load_val(sp_load_val),
        .busy(busy), .sp(sp), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_wr_data(mem_wr_data), .mem_rd_data(mem_rd_data),
        .pop_valid(pop_valid), .pop_data(pop_data)
    );

    // Bench memory driven by the DUT's port
    logic [DW-1:0] bmem [int];
    always @(posedge clk) begin
        if (mem_wr_en) bmem[int'(mem_addr)] = mem_wr_data;
        if (mem_rd_en) mem_rd_data <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : '0;
    end

    // Behavioural reference model
    logic [DW-1:0] mmem [int];
    int            m_sp;
    bit            m_busy, m_vld;
    logic [DW-1:0] m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sp = int'(RST_SP) & 32'hFFFC; m_busy = 0; m_vld = 0;
        end else if (m_busy) begin
            m_busy = 0; m_vld = 0;
            if (sp_load) m_sp = int'(sp_load_val) & 32'hFFFC;
            else         m_sp = (m_sp + 4) % 65536;
        end else begin
            m_vld = 0;
            if (sp_load) m_sp = int'(sp_load_val) & 32'hFFFC;
            else if (push_req) begin
                m_sp = (m_sp + 65536 - 4) % 65536;
                mmem[m_sp] = push_data;
            end else if (pop_req) begin
                m_data = mmem.exists(m_sp) ? mmem[m_sp] : '0;
                m_vld = 1; m_busy = 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_we, exp_re;
            int exp_addr;
            exp_we = !m_busy && !sp_load && push_req;
            exp_re = !m_busy && !sp_load && !push_req && pop_req;
            exp_addr = exp_we ? (m_sp + 65536 - 4) % 65536 : m_sp;
            check(int'(sp) == m_sp, "R3 sp", int'(sp), m_sp);
            check(busy == m_busy, "R5 busy", int'(busy), int'(m_busy));
            check(pop_valid == m_vld, "R4 pop_valid", int'(pop_valid), int'(m_vld));
            if (m_vld) check(pop_data == m_data, "R9 pop_data", int'(pop_data), int'(m_data));
            check(mem_wr_en == exp_we, "R6 mem_wr_en", int'(mem_wr_en), int'(exp_we));
            check(mem_rd_en == exp_re, "R6 mem_rd_en", int'(mem_rd_en), int'(exp_re));
            if (exp_we || exp_re) check(int'(mem_addr) == exp_addr, "R3 mem_addr", int'(mem_addr), exp_addr);
            if (exp_we) check(mem_wr_data == push_data, "R3 mem_wr_data", int'(mem_wr_data), int'(push_data));
        end
    end

    task automatic drive(input bit pu, input logic [DW-1:0] pd, input bit po,
                         input bit ld, input logic [AW-1:0] lv);
        @(posedge clk); #1;
        push_req = pu; push_data = pd; pop_req = po; sp_load = ld; sp_load_val = lv;
        cyc++;
    endtask

    task automatic idle();
        drive(0, '0, 0, 0, '0);
    endtask

    task automatic pop_expect(input logic [DW-1:0] v, input string tag);
        drive(0, '0, 1, 0, '0);
        idle();
        @(negedge clk);
        check(pop_valid && pop_data == v, tag, int'(pop_data), int'(v));
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired (R1) actual 0 expected 1");
            finish_run();
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(sp == 16'h0008, "R1 reset sp", int'(sp), 8);
        check(!busy && !pop_valid && !mem_wr_en && !mem_rd_en, "R1 reset flags", 0, 0);

        // R3 / R9: push three, pointer wraps below zero (R8)
        drive(1, 16'hA001, 0, 0, '0);
        drive(1, 16'hA002, 0, 0, '0);
        drive(1, 16'hA003, 0, 0, '0);
        idle();
        @(negedge clk);
        check(sp == 16'hFFFC, "R8 wrap below zero", int'(sp), 16'hFFFC);
        pop_expect(16'hA003, "R9 lifo first");
        pop_expect(16'hA002, "R9 lifo second");
        @(negedge clk);
        check(sp == 16'h0004, "R4 post-increment", int'(sp), 4);

        // R6: push and pop together
        drive(1, 16'hB0B0, 1, 0, '0);
        idle();
        @(negedge clk);
        check(sp == 16'h0000 && !pop_valid, "R6 push wins", int'(sp), 0);

        // R5: requests during busy ignored
        drive(0, '0, 1, 0, '0);
        drive(1, 16'hDEAD, 1, 0, '0);
        @(negedge clk);
        check(busy && !mem_wr_en && !mem_rd_en, "R5 busy ignores", int'(mem_wr_en), 0);
        idle();
        @(negedge clk);
        check(sp == 16'h0004, "R5 only pop increment", int'(sp), 4);

        // R7: load during busy cancels increment, data still delivered
        drive(0, '0, 1, 0, '0);
        drive(0, '0, 0, 1, 16'h0100);
        @(negedge clk);
        check(pop_valid && pop_data == 16'hA001, "R7 pop data kept", int'(pop_data), 16'hA001);
        idle();
        @(negedge clk);
        check(sp == 16'h0100, "R7 load over increment", int'(sp), 16'h0100);

        // R7 + R2: load with push, unaligned value
        drive(1, 16'h5555, 0, 1, 16'h1237);
        @(negedge clk);
        check(!mem_wr_en, "R7 load blocks push", int'(mem_wr_en), 0);
        idle();
        @(negedge clk);
        check(sp == 16'h1234, "R2 load aligned", int'(sp), 16'h1234);

        // R8: wrap above the top
        drive(0, '0, 0, 1, 16'hFFFC);
        drive(0, '0, 1, 0, '0);
        idle(); idle();
        @(negedge clk);
        check(sp == 16'h0000, "R8 wrap above top", int'(sp), 0);

        // Mixed pseudo-random traffic against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0] & ~lfsr[1], lfsr ^ 16'h3C3C, lfsr[2],
                  (lfsr[7:3] == 5'd0), {lfsr[8] ? 4'hF : 4'h0, lfsr[11:0]});
        end
        idle(); idle();
        done = 1;
        finish_run();
    end

endmodule